// File: doc/BRIEF.md
# 16-bit Integer Execute Unit

A purely combinational arithmetic, logic and shift unit for a small 16-bit core with eight general registers. It receives two already-selected operands, `a_i` (the first source register) and `b_i` (the second source register or an extended immediate), plus a 4-bit function code. It returns one 16-bit result in the same evaluation. Nothing is stored, so the unit sits directly between operand selection and write-back.

The function set includes some operations that a plain ALU lacks. Subtraction takes the first operand away from the second. There is a flag that reports the carry out of an unsigned add, a full bit reversal, and a byte-insert step that shifts the first operand up by eight and places the low byte of the second operand in the freed bits. Shifts and rotates read only the low four bits of `b_i`.

Top module: `alu16_unit`

## Requirements
- R1: Code 0000 returns `a_i + b_i` modulo 2^16.
- R2: Code 0001 returns `b_i - a_i` modulo 2^16 (second operand minus first).
- R3: Code 0010 returns `a_i | b_i` and code 0011 returns `a_i & b_i`.
- R4: Codes 0100, 0101, 0110 and 0111 rotate `a_i` left, shift it left logically, rotate it right, and shift it right arithmetically (sign bit copied in). The amount is `b_i[3:0]`, and an amount of 0 returns `a_i` unchanged.
- R5: For codes 0100 to 0111, `b_i[15:4]` has no effect on the result.
- R6: Codes 1000, 1001 and 1010 compare `a_i` with `b_i` as two's-complement numbers, testing a==b, a<b and a<=b in that order. They return 0x0001 when the test holds and 0x0000 when it does not.
- R7: Code 1011 returns 0x0001 exactly when the unsigned sum `a_i + b_i` carries out of bit 15, and 0x0000 otherwise.
- R8: Code 1100 returns `a_i` with its bits reversed, so that input bit i appears at output bit 15-i.
- R9: Code 1101 returns `{a_i[7:0], b_i[7:0]}`, which is `a_i` shifted left by 8 with its low byte taken from `b_i`.
- R10: Codes 1110 and 1111 return 0x0000 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand (source register) |
| b_i | input | 16 | Second operand; also the shift amount and the inserted byte |
| func_i | input | 4 | Function code |
| result_o | output | 16 | Function result |

## Verification
The hardest cases to reach are the edges where a careless implementation still looks right for typical values. These are the signed compares at 0x7FFF against 0x8000, where an unsigned compare gives the opposite answer, and the arithmetic right shift of a negative value by 15. Uniform random operands almost never land on them. The stimulus therefore places directed vectors on those values and on shift amounts 0 and 15. It also repeats each shift with the upper bits of the amount operand set, to show they are ignored. Random vectors biased toward 0x0000, 0xFFFF, 0x7FFF and 0x8000 then cover all sixteen function codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    FN_ADD  = 4'b0000,
    FN_SUB  = 4'b0001,
    FN_OR   = 4'b0010,
    FN_AND  = 4'b0011,
    FN_ROL  = 4'b0100,
    FN_SLL  = 4'b0101,
    FN_ROR  = 4'b0110,
    FN_SRA  = 4'b0111,
    FN_SEQ  = 4'b1000,
    FN_SLT  = 4'b1001,
    FN_SLE  = 4'b1010,
    FN_SCO  = 4'b1011,
    FN_BREV = 4'b1100,
    FN_BINS = 4'b1101
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_ROL = 2'b00,
    SH_SLL = 2'b01,
    SH_ROR = 2'b10,
    SH_SRA = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] and_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         cout_o
);
  logic [W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    sum_o    = wide_sum[W-1:0];
    cout_o   = wide_sum[W];
    diff_o   = b_i - a_i;          // reversed order
    or_o     = a_i | b_i;
    and_o    = a_i & b_i;
    eq_o     = (a_i == b_i);
    lt_o     = ($signed(a_i) < $signed(b_i));
    le_o     = lt_o | eq_o;
  end

  always_comb begin
    assert_le_cover_R6: assert (!(eq_o && lt_o));
    assert_carry_wrap_R7: assert (cout_o == (sum_o < a_i));
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16,
  localparam int SHAMT_W = $clog2(W)
) (
  input  logic [W-1:0]       data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  shift_mode_e        mode_i,
  output logic [W-1:0]       data_o
);
  logic [W-1:0] stage [SHAMT_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      unique case (mode_i)
        SH_ROL:  moved = {stage[s][W-K-1:0], stage[s][W-1:W-K]};
        SH_SLL:  moved = {stage[s][W-K-1:0], {K{1'b0}}};
        SH_ROR:  moved = {stage[s][K-1:0], stage[s][W-1:K]};
        default: moved = {{K{stage[s][W-1]}}, stage[s][W-1:K]};
      endcase
    end
    assign stage[s+1] = amt_i[s] ? moved : stage[s];
  end

  assign data_o = stage[SHAMT_W];

  always_comb begin
    assert_zero_amt_R4: assert (amt_i != '0 || data_o == data_i);
    assert_sra_sign_R4: assert (mode_i != SH_SRA || data_o[W-1] == data_i[W-1]);
    assert_rot_ones_R4: assert (mode_i == SH_SLL || mode_i == SH_SRA
                                || $countones(data_o) == $countones(data_i));
  end
endmodule

// File: rtl/alu16_bits.sv
module alu16_bits #(
  parameter int W      = 16,
  parameter int LOAD_W = 8
) (
  input  logic [W-1:0]      a_i,
  input  logic [LOAD_W-1:0] byte_i,
  output logic [W-1:0]      rev_o,
  output logic [W-1:0]      ins_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_o[i] = a_i[W-1-i];
  end

  assign ins_o = {a_i[W-LOAD_W-1:0], byte_i};

  always_comb begin
    assert_rev_ones_R8: assert ($countones(rev_o) == $countones(a_i));
    assert_rev_ends_R8: assert (rev_o[0] == a_i[W-1] && rev_o[W-1] == a_i[0]);
  end
endmodule

// File: rtl/alu16_unit.sv
module alu16_unit
  import alu16_pkg::*;
#(
  parameter int W      = 16,
  parameter int LOAD_W = 8,
  localparam int SHAMT_W = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   func_i,
  output logic [W-1:0] result_o
);
  logic [W-1:0] sum, diff, or_v, and_v, shifted, rev, ins;
  logic         eq, lt, le, cout;
  shift_mode_e  sh_mode;

  alu16_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i),
    .sum_o(sum), .diff_o(diff), .or_o(or_v), .and_o(and_v),
    .eq_o(eq), .lt_o(lt), .le_o(le), .cout_o(cout)
  );

  assign sh_mode = shift_mode_e'(func_i[1:0]);

  alu16_shift #(.W(W)) u_shift (
    .data_i(a_i), .amt_i(b_i[SHAMT_W-1:0]), .mode_i(sh_mode), .data_o(shifted)
  );

  alu16_bits #(.W(W), .LOAD_W(LOAD_W)) u_bits (
    .a_i(a_i), .byte_i(b_i[LOAD_W-1:0]), .rev_o(rev), .ins_o(ins)
  );

  function automatic logic [W-1:0] flag(input logic f);
    return {{(W-1){1'b0}}, f};
  endfunction

  always_comb begin
    case (func_i)
      FN_ADD:  result_o = sum;
      FN_SUB:  result_o = diff;
      FN_OR:   result_o = or_v;
      FN_AND:  result_o = and_v;
      FN_ROL, FN_SLL, FN_ROR, FN_SRA: result_o = shifted;
      FN_SEQ:  result_o = flag(eq);
      FN_SLT:  result_o = flag(lt);
      FN_SLE:  result_o = flag(le);
      FN_SCO:  result_o = flag(cout);
      FN_BREV: result_o = rev;
      FN_BINS: result_o = ins;
      default: result_o = '0;
    endcase
  end

  always_comb begin
    assert_sub_order_R2: assert (func_i != FN_SUB || (W'(result_o + a_i) == b_i));
    assert_add_back_R1: assert (func_i != FN_ADD || (W'(result_o - b_i) == a_i));
    assert_flag_width_R6: assert (func_i[3:2] != 2'b10 || result_o[W-1:1] == '0);
    assert_ins_high_R9: assert (func_i != FN_BINS || result_o[W-1:LOAD_W] == a_i[W-LOAD_W-1:0]);
    assert_undef_zero_R10: assert (func_i[3:1] != 3'b111 || result_o == '0);
  end
endmodule

// File: tb/alu16_unit_bench.sv
module alu16_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a, b, res;
  logic [3:0]  fn;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  alu16_unit u_alu16_unit (.a_i(a), .b_i(b), .func_i(fn), .result_o(res));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] model(input logic [3:0] f, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] r;
    int n;
    n = int'(y[3:0]);
    r = 16'h0000;
    case (f)
      4'd0: r = x + y;
      4'd1: r = y - x;
      4'd2: r = x | y;
      4'd3: r = x & y;
      4'd4: for (int i = 0; i < 16; i++) r[(i + n) % 16] = x[i];
      4'd5: r = x << n;
      4'd6: for (int i = 0; i < 16; i++) r[i] = x[(i + n) % 16];
      4'd7: r = 16'($signed(x) >>> n);
      4'd8: r = (x == y) ? 16'd1 : 16'd0;
      4'd9: r = ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
      4'd10: r = ($signed(x) <= $signed(y)) ? 16'd1 : 16'd0;
      4'd11: r = ((32'(x) + 32'(y)) > 32'hFFFF) ? 16'd1 : 16'd0;
      4'd12: for (int i = 0; i < 16; i++) r[15 - i] = x[i];
      4'd13: r = {x[7:0], y[7:0]};
      default: r = 16'h0000;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10: return "R6";
      4'd11: return "R7";
      4'd12: return "R8";
      4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [3:0] f, input logic [15:0] x, input logic [15:0] y, input string tag);
    logic [15:0] exp_v;
    fn = f; a = x; b = y;
    @(negedge clk);
    exp_v = model(f, x, y);
    checks = checks + 1;
    if (res !== exp_v) begin
      errors = errors + 1;
      $display("FAIL %s fn=%0d a=%h b=%h actual=%h expected=%h", tag, f, x, y, res, exp_v);
    end
  endtask

  function automatic logic [15:0] corner(input int sel);
    case (sel)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h8000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A1B));
    fn = 4'd0; a = 16'h0; b = 16'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(4'd0, 16'h0000, 16'h0000, "R1 reset-state zero");
    run(4'd0, 16'hFFFF, 16'h0001, "R1 wrap");
    run(4'd1, 16'h0003, 16'h0005, "R2 b-a positive");
    run(4'd1, 16'h0005, 16'h0003, "R2 b-a negative");
    run(4'd2, 16'hF0F0, 16'h0F0F, "R3 or");
    run(4'd3, 16'hF0F0, 16'h3C3C, "R3 and");
    for (int f = 4; f < 8; f++) begin
      run(4'(f), 16'h8001, 16'h0000, "R4 amount 0");
      run(4'(f), 16'h8001, 16'h000F, "R4 amount 15");
      run(4'(f), 16'hF0F0, 16'h0004, "R4 negative operand");
      run(4'(f), 16'h8000, 16'h000F, "R4 negative by 15");
      run(4'(f), 16'h9235, 16'hFFF3, "R5 upper amount bits set");
      run(4'(f), 16'h9235, 16'hA5A3, "R5 upper amount bits mixed");
    end
    run(4'd8, 16'h7FFF, 16'h7FFF, "R6 eq true");
    run(4'd8, 16'h7FFF, 16'h8000, "R6 eq false");
    run(4'd9, 16'h8000, 16'h7FFF, "R6 lt signed true");
    run(4'd9, 16'h7FFF, 16'h8000, "R6 lt signed false");
    run(4'd10, 16'h8000, 16'h8000, "R6 le equal");
    run(4'd10, 16'h7FFF, 16'h8000, "R6 le false");
    run(4'd10, 16'hFFFF, 16'h0000, "R6 le negative");
    run(4'd11, 16'hFFFF, 16'h0001, "R7 carry");
    run(4'd11, 16'hFFFF, 16'h0000, "R7 no carry");
    run(4'd11, 16'h8000, 16'h8000, "R7 msb carry");
    run(4'd12, 16'h0001, 16'h1234, "R8 bit0");
    run(4'd12, 16'hC035, 16'h0000, "R8 pattern");
    run(4'd13, 16'h12AB, 16'hFFCD, "R9 insert");
    run(4'd14, 16'hFFFF, 16'hFFFF, "R10 code 14");
    run(4'd15, 16'h8000, 16'h7FFF, "R10 code 15");
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] f;
      f = 4'($urandom_range(0, 15));
      run(f, corner($urandom_range(0, 7)), corner($urandom_range(0, 7)), req_of(f));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule